// File: doc/BRIEF.md
# Local Exclusive Access Monitor

This block is the per-core half of an exclusive-access reservation scheme. It watches one core's stream of memory operations: ordinary loads, load-exclusives, ordinary stores and store-exclusives. From that stream it decides whether each store-exclusive may proceed. It never touches memory. It keeps a two-state reservation that records a coarse address tag and the access size of the most recent load-exclusive.

Requests arrive on one port, at most one per cycle, and only while `req_valid_i` is high. Each store-exclusive produces a registered pass/fail result in the following cycle, both as a pass flag and as the status word that software sees. A local pass is only a permission. A separate system-wide monitor must also agree before the surrounding logic commits the write.

Top module: `excl_monitor`

## Requirements
- R1: After reset the monitor holds no reservation: its state is Open, the recorded size is None (0) and the tag is zero, no response is pending, and a store-exclusive issued first fails.
- R2: A request is taken only in a cycle where `req_valid_i` is 1. With `req_valid_i` at 0, the op, address and size inputs have no effect on the reservation.
- R3: Op code 1 (load-exclusive) records the tag and size and enters Exclusive. A later load-exclusive replaces both values.
- R4: Op code 3 (store-exclusive) passes only in Exclusive, with an equal tag and a size equal to the recorded one. Size codes are None=0, Byte=1, Half=2, Word=4.
- R5: The tag is address bits [31:11]. The low 11 bits are forced to zero before they are stored and before any comparison, so addresses inside one 2 KiB region match.
- R6: Every store-exclusive, whether it passes or fails, returns the monitor to Open with size None. A second store-exclusive right after it therefore fails.
- R7: Op code 2 (plain store) whose tag equals the recorded tag, while in Exclusive, drops the reservation. A plain store to another tag leaves the reservation in place.
- R8: Op code 0 (plain load) leaves state, tag and size unchanged.
- R9: `rsp_valid_o` is 1 in exactly the cycle after an accepted store-exclusive and at no other time. `rsp_status_o` is 0 on pass and 1 on fail. `rsp_pass_o` is its inverse and is 0 whenever no response is present.
- R10: Requests may arrive back to back. A store-exclusive in the cycle right after a load-exclusive sees the new reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 2 | 0 load, 1 load-exclusive, 2 store, 3 store-exclusive |
| req_addr_i | input | 32 | Byte address of the access |
| req_size_i | input | 3 | Access size code: 0 none, 1 byte, 2 half, 4 word |
| rsp_valid_o | output | 1 | Store-exclusive result present |
| rsp_pass_o | output | 1 | Local check allows the store |
| rsp_status_o | output | 1 | Software status: 0 pass, 1 fail |

## Verification
The bound checker checks these on every cycle:
- a response appears only after a store-exclusive, and its status and pass flag are consistent;
- a pass comes only from Exclusive with an equal size;
- every store-exclusive closes the reservation, and every load-exclusive opens it;
- plain loads and idle cycles leave the reservation alone;
- a plain store with a matching tag clears it;
- the stored tag keeps its low bits at zero.

Some behaviours only the bench scenarios can show. These are the full pass/fail results across sequences:
- tag aliasing inside one 2 KiB region, and a miss across a region boundary;
- size mismatches;
- a load-exclusive that replaces an earlier one;
- inputs ignored while valid is low;
- back-to-back pairs.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  localparam int SIZE_W = 3;

  typedef enum logic [1:0] {
    OP_LOAD     = 2'd0,
    OP_LOAD_EX  = 2'd1,
    OP_STORE    = 2'd2,
    OP_STORE_EX = 2'd3
  } mon_op_e;

  typedef enum logic {
    MON_OPEN = 1'b0,
    MON_EXCL = 1'b1
  } mon_state_e;

  localparam logic [SIZE_W-1:0] SZ_NONE = 3'd0;
  localparam logic [SIZE_W-1:0] SZ_BYTE = 3'd1;
  localparam logic [SIZE_W-1:0] SZ_HALF = 3'd2;
  localparam logic [SIZE_W-1:0] SZ_WORD = 3'd4;
endpackage

// File: rtl/excl_mon_decode.sv
module excl_mon_decode
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TAG_LSB = 11
) (
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] tag_o,
  output logic              ldex_o,
  output logic              st_o,
  output logic              stex_o
);
  localparam logic [ADDR_W-1:0] TAG_MASK = ~((ADDR_W'(1) << TAG_LSB) - ADDR_W'(1));

  mon_op_e op;
  assign op    = mon_op_e'(op_i);
  assign tag_o = addr_i & TAG_MASK;

  always_comb begin
    ldex_o = 1'b0;
    st_o   = 1'b0;
    stex_o = 1'b0;
    if (valid_i) begin
      unique case (op)
        OP_LOAD_EX:  ldex_o = 1'b1;
        OP_STORE:    st_o   = 1'b1;
        OP_STORE_EX: stex_o = 1'b1;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/excl_mon_fsm.sv
module excl_mon_fsm
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ldex_i,
  input  logic              st_i,
  input  logic              stex_i,
  input  logic [ADDR_W-1:0] tag_i,
  input  logic [SIZE_W-1:0] size_i,
  output mon_state_e        state_o,
  output logic [ADDR_W-1:0] tag_o,
  output logic [SIZE_W-1:0] size_o,
  output logic              pass_o
);
  mon_state_e        state_q, state_d;
  logic [ADDR_W-1:0] tag_q, tag_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic              tag_hit;

  assign tag_hit = (tag_q == tag_i);
  assign pass_o  = stex_i && (state_q == MON_EXCL) && tag_hit && (size_q == size_i);

  always_comb begin
    state_d = state_q;
    tag_d   = tag_q;
    size_d  = size_q;
    if (ldex_i) begin
      state_d = MON_EXCL;
      tag_d   = tag_i;
      size_d  = size_i;
    end else if (stex_i) begin
      state_d = MON_OPEN;
      size_d  = SZ_NONE;
    end else if (st_i && state_q == MON_EXCL && tag_hit) begin
      state_d = MON_OPEN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MON_OPEN;
      tag_q   <= '0;
      size_q  <= SZ_NONE;
    end else begin
      state_q <= state_d;
      tag_q   <= tag_d;
      size_q  <= size_d;
    end
  end

  assign state_o = state_q;
  assign tag_o   = tag_q;
  assign size_o  = size_q;
endmodule

// File: rtl/excl_mon_resp.sv
module excl_mon_resp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stex_i,
  input  logic pass_i,
  output logic rsp_valid_o,
  output logic rsp_pass_o,
  output logic rsp_status_o
);
  logic valid_q, pass_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      valid_q <= stex_i;
      pass_q  <= stex_i && pass_i;
    end
  end

  assign rsp_valid_o  = valid_q;
  assign rsp_pass_o   = pass_q;
  // software status word: 0 success, 1 failure
  assign rsp_status_o = valid_q && !pass_q;
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TAG_LSB = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [2:0]        req_size_i,
  output logic              rsp_valid_o,
  output logic              rsp_pass_o,
  output logic              rsp_status_o
);
  logic [ADDR_W-1:0] req_tag;
  logic              is_ldex, is_st, is_stex, local_pass;
  mon_state_e        mon_state;
  logic [ADDR_W-1:0] rec_tag;
  logic [SIZE_W-1:0] rec_size;

  excl_mon_decode #(.ADDR_W(ADDR_W), .TAG_LSB(TAG_LSB)) u_decode (
    .valid_i (req_valid_i),
    .op_i    (req_op_i),
    .addr_i  (req_addr_i),
    .tag_o   (req_tag),
    .ldex_o  (is_ldex),
    .st_o    (is_st),
    .stex_o  (is_stex)
  );

  excl_mon_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ldex_i  (is_ldex),
    .st_i    (is_st),
    .stex_i  (is_stex),
    .tag_i   (req_tag),
    .size_i  (req_size_i),
    .state_o (mon_state),
    .tag_o   (rec_tag),
    .size_o  (rec_size),
    .pass_o  (local_pass)
  );

  excl_mon_resp u_resp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stex_i       (is_stex),
    .pass_i       (local_pass),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_pass_o   (rsp_pass_o),
    .rsp_status_o (rsp_status_o)
  );
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TAG_LSB = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        req_op_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [2:0]        req_size_i,
  input logic              rsp_valid_o,
  input logic              rsp_pass_o,
  input logic              rsp_status_o,
  input mon_state_e        state_i,
  input logic [ADDR_W-1:0] tag_i,
  input logic [SIZE_W-1:0] size_i
);
  logic is_ld, is_ldex, is_st, is_stex, st_hit;
  assign is_ld   = req_valid_i && req_op_i == OP_LOAD;
  assign is_ldex = req_valid_i && req_op_i == OP_LOAD_EX;
  assign is_st   = req_valid_i && req_op_i == OP_STORE;
  assign is_stex = req_valid_i && req_op_i == OP_STORE_EX;
  assign st_hit  = is_st && state_i == MON_EXCL &&
                   req_addr_i[ADDR_W-1:TAG_LSB] == tag_i[ADDR_W-1:TAG_LSB];

  assert_reset_open_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (state_i == MON_OPEN && size_i == SZ_NONE && !rsp_valid_o));

  assert_idle_no_effect_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(state_i) && $stable(size_i) && $stable(tag_i)));

  assert_ldex_arms_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ldex |=> (state_i == MON_EXCL && size_i == $past(req_size_i)));

  assert_pass_needs_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_pass_o |-> ($past(state_i) == MON_EXCL && $past(req_size_i) == $past(size_i)));

  assert_tag_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_i[TAG_LSB-1:0] == '0);

  assert_stex_closes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_stex |=> (state_i == MON_OPEN && size_i == SZ_NONE));

  assert_hit_store_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_hit |=> state_i == MON_OPEN);

  assert_load_no_effect_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ld |=> ($stable(state_i) && $stable(size_i) && $stable(tag_i)));

  assert_rsp_after_stex_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(is_stex));

  assert_stex_gets_rsp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_stex |=> rsp_valid_o);

  assert_status_inverse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_status_o == !rsp_pass_o));

  assert_pass_in_rsp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_pass_o |-> rsp_valid_o);
endmodule

bind excl_monitor excl_monitor_chk #(.ADDR_W(ADDR_W), .TAG_LSB(TAG_LSB)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_op_i     (req_op_i),
  .req_addr_i   (req_addr_i),
  .req_size_i   (req_size_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_pass_o   (rsp_pass_o),
  .rsp_status_o (rsp_status_o),
  .state_i      (mon_state),
  .tag_i        (rec_tag),
  .size_i       (rec_size)
);

// File: tb/excl_monitor_tb.sv
module excl_monitor_tb;
  localparam logic [1:0] LD = 2'd0, LDX = 2'd1, ST = 2'd2, STX = 2'd3;
  localparam logic [2:0] NO = 3'd0, BY = 3'd1, HW = 3'd2, WD = 3'd4;

  typedef struct {
    logic  ev;
    logic  ep;
    string req;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_valid_i;
  logic [1:0]  req_op_i;
  logic [31:0] req_addr_i;
  logic [2:0]  req_size_i;
  logic        rsp_valid_o, rsp_pass_o, rsp_status_o;

  int   checks = 0;
  int   errors = 0;
  bit   mon_en = 1'b0;
  exp_t sb_q[$];

  always #2.5 clk_i = ~clk_i;

  excl_monitor u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_op_i     (req_op_i),
    .req_addr_i   (req_addr_i),
    .req_size_i   (req_size_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_pass_o   (rsp_pass_o),
    .rsp_status_o (rsp_status_o)
  );

  task automatic drive(input logic v, input logic [1:0] op, input logic [31:0] a,
                       input logic [2:0] sz, input logic ev, input logic ep,
                       input string req);
    exp_t e;
    @(negedge clk_i);
    req_valid_i = v;
    req_op_i    = op;
    req_addr_i  = a;
    req_size_i  = sz;
    e.ev = ev;
    e.ep = ep;
    e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor: compare each cycle's response with the queued expectation
  always @(posedge clk_i) begin
    if (mon_en) begin
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        logic exp_st;
        e = sb_q.pop_front();
        exp_st = e.ev && !e.ep;
        checks++;
        if (rsp_valid_o !== e.ev || rsp_pass_o !== (e.ev && e.ep) || rsp_status_o !== exp_st) begin
          errors++;
          $display("FAIL %s: valid/pass/status got %b%b%b expected %b%b%b",
                   e.req, rsp_valid_o, rsp_pass_o, rsp_status_o, e.ev, e.ev && e.ep, exp_st);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam logic [31:0] A = 32'h2000_0040;
  localparam logic [31:0] B = 32'h2000_0840;

  initial begin
    rst_ni = 1'b0;
    req_valid_i = 1'b0;
    req_op_i = LD;
    req_addr_i = '0;
    req_size_i = NO;
    repeat (3) @(negedge clk_i);
    checks++;
    if (rsp_valid_o !== 1'b0 || rsp_pass_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: valid/pass got %b%b expected 00", rsp_valid_o, rsp_pass_o);
    end
    rst_ni = 1'b1;
    mon_en = 1'b1;

    // R1: no reservation after reset
    drive(1, STX, 32'h0, NO, 1, 0, "R1 first stex");
    // R3 R4 R9 R10: back-to-back pair passes
    drive(1, LDX, A, WD, 0, 0, "R9 ldex no rsp");
    drive(1, STX, A, WD, 1, 1, "R4 matching pair");
    // R6: second store-exclusive fails
    drive(1, STX, A, WD, 1, 0, "R6 repeat stex");
    // R4 size mismatch, then R6 cleared
    drive(1, LDX, A, WD, 0, 0, "R3 ldex");
    drive(1, STX, A, HW, 1, 0, "R4 size mismatch");
    drive(1, STX, A, WD, 1, 0, "R6 cleared after fail");
    // R5: same 2 KiB region matches
    drive(1, LDX, 32'h1000_0800, BY, 0, 0, "R3 ldex byte");
    drive(1, STX, 32'h1000_0FFF, BY, 1, 1, "R5 low bits ignored");
    // R5/R4: next region misses
    drive(1, LDX, 32'h1000_0800, BY, 0, 0, "R3 ldex byte");
    drive(1, STX, 32'h1000_1000, BY, 1, 0, "R5 region boundary miss");
    // R7: plain store same tag clears
    drive(1, LDX, A, WD, 0, 0, "R3 ldex");
    drive(1, ST, A + 32'd4, WD, 0, 0, "R9 store no rsp");
    drive(1, STX, A, WD, 1, 0, "R7 hit store cleared");
    // R7: plain store other tag keeps
    drive(1, LDX, A, HW, 0, 0, "R3 ldex half");
    drive(1, ST, B, WD, 0, 0, "R9 store no rsp");
    drive(1, STX, A, HW, 1, 1, "R7 miss store kept");
    // R8: plain load keeps
    drive(1, LDX, A, WD, 0, 0, "R3 ldex");
    drive(1, LD, A, WD, 0, 0, "R9 load no rsp");
    drive(1, STX, A, WD, 1, 1, "R8 load no effect");
    // R2: invalid cycles ignored
    drive(1, LDX, A, WD, 0, 0, "R3 ldex");
    drive(0, ST, A, WD, 0, 0, "R2 idle store");
    drive(0, STX, A, WD, 0, 0, "R2 idle stex");
    drive(1, STX, A, WD, 1, 1, "R2 reservation survived");
    // R3: newer ldex replaces older
    drive(1, LDX, A, WD, 0, 0, "R3 ldex A");
    drive(1, LDX, B, BY, 0, 0, "R3 ldex B");
    drive(1, STX, A, WD, 1, 0, "R3 replaced reservation");
    drive(1, LDX, B, BY, 0, 0, "R3 ldex B");
    drive(1, STX, B, BY, 1, 1, "R3 newest reservation");
    // R4: store-exclusive without ldex in Open fails
    drive(1, STX, B, BY, 1, 0, "R4 open state");
    drive(0, LD, '0, NO, 0, 0, "R9 idle");
    drive(0, LD, '0, NO, 0, 0, "R9 idle");

    repeat (3) @(posedge clk_i);
    mon_en = 1'b0;
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R9 drain: pending got %0d expected 0", sb_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule